// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-controlled master for the IEEE 802.3 management interface (MDIO/MDC). Software sees two 16-bit registers: a command word and a data word. To issue an operation it loads the data word, then writes a command word with the busy flag set. The engine then serialises one complete management frame, in either Clause 22 or Clause 45 format, onto one of two physical buses. One bus serves internal PHYs and the other serves external ones.

The data word has three roles. It is the write payload, it is the 16-bit register address for a Clause 45 address cycle, and it receives the read result. Busy stays set until the last bit of the frame has been clocked. Software polls the command word and issues the next command only after busy has cleared. A Clause 45 register read therefore takes two commands: an address write, then a read.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, both registers read 0x0000, both MDC outputs are low and both MDIO output enables are low.
- R2: A register bus write or read at address 0x18 reaches the command word and one at address 0x19 reaches the data word. Reads of any other address return 0x0000.
- R3: A command word written while idle, with bit 15 set and function bits 14:13 equal to 00 or 01, starts a frame. Bit 15 then reads 1 until the frame has finished and 0 afterwards. Bits 14:0 read back as written.
- R4: A command word whose function bits 14:13 are 10 or 11 starts no frame. Its bits 14:0 are stored, bit 15 reads 0, and neither bus sees any MDC edge.
- R5: Function 00 drives the internal bus and function 01 drives the external bus. The MDC and output enable of the other bus stay low for the whole frame.
- R6: Every frame has 64 bits, sent MSB first with one bit per MDC period. The master changes a bit after a falling MDC edge. The frame is 32 ones, then start code 01 when bit 12 = 1 (Clause 22) or 00 when bit 12 = 0 (Clause 45), then opcode bits 11:10, then address bits 9:5, then address bits 4:0.
- R7: For a write-type opcode (bit 11 = 0), the last 18 bits are turnaround 10 followed by the data word. The output enable stays high for all 64 bits.
- R8: For a read-type opcode (bit 11 = 1), the output enable is low from bit 46 (turnaround) to the end of the frame. The 16 bits sampled on the rising MDC edges of bits 48 to 63 are written to the data word when busy clears.
- R9: While busy is 1, writes to the command word and to the data word have no effect.
- R10: MDC runs with a period of 2*DIV_HALF clock cycles only while a frame is in progress. Busy stays set for exactly 128*DIV_HALF cycles after the accepting clock edge.
- R11: A Clause 45 address write (opcode 00) carrying the data word, followed by a Clause 45 read (opcode 11), returns the PHY's word in the data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| mdc_int | output | 1 | Management clock, internal bus |
| mdio_int_o | output | 1 | MDIO output data, internal bus |
| mdio_int_oe | output | 1 | MDIO output enable, internal bus |
| mdio_int_i | input | 1 | MDIO input data, internal bus |
| mdc_ext | output | 1 | Management clock, external bus |
| mdio_ext_o | output | 1 | MDIO output data, external bus |
| mdio_ext_oe | output | 1 | MDIO output enable, external bus |
| mdio_ext_i | input | 1 | MDIO input data, external bus |

## Verification
The assertions check on every cycle that the two buses never clock or drive at the same time. They also check that MDC is quiet and no output is enabled outside a busy period, and that neither register moves while busy except at the completion edge. Only the bench scenarios can show the frame contents bit by bit, the turnaround release, the captured read word, the exact busy duration, the refusal of setup-type functions, and the two-step Clause 45 read. The bench does this with a bus-side responder that records every rising MDC edge.

// File: rtl/mdio_eng_pkg.sv
// Package: shared command-word layout and constants for the MDIO command engine.
// Assumes a 16-bit command word whose field positions are fixed by software.
package mdio_eng_pkg;
    localparam int WORD_W   = 16;
    localparam int FRAME_W  = 64;
    localparam int PRE_W    = 32;
    localparam int TA_IDX   = 46;   // first turnaround bit in the frame
    localparam int RDAT_IDX = 48;   // first read data bit in the frame

    typedef enum logic [1:0] {
        FN_INT   = 2'b00,
        FN_EXT   = 2'b01,
        FN_SETUP = 2'b10,
        FN_RSVD  = 2'b11
    } func_e;

    typedef struct packed {
        logic       busy;
        func_e      func;
        logic       c22;
        logic [1:0] op;
        logic [4:0] phy;
        logic [4:0] regad;
    } cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
// Module: MDC generator. Produces a 50% duty MDC from clk while run is high,
// with one-cycle pulses on the clk edge where MDC rises or falls.
// Assumes run is high for the whole frame; MDC is held low when run is low.
module mdio_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = run && (cnt == CW'(DIV_HALF - 1));
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    // Count half periods and toggle MDC at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_framer.sv
// Module: frame shifter. Loads a 64-bit frame on start, presents bits MSB
// first, advances on MDC falls and samples read data on MDC rises.
// Assumes start only arrives while idle; done pulses on the final fall.
module mdio_framer
    import mdio_eng_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               is_read,
    input  logic               rise,
    input  logic               fall,
    input  logic               sdi,
    output logic               active,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               done,
    output logic [WORD_W-1:0]  rx_word
);
    localparam int IW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sreg;
    logic [IW-1:0]      idx;
    logic               rd_q;

    assign done   = active && fall && (idx == IW'(FRAME_W - 1));
    assign sdo    = active ? sreg[FRAME_W-1] : 1'b1;
    assign sdo_oe = active && !(rd_q && (idx >= IW'(TA_IDX)));

    // Frame sequencing: load, shift on falling MDC, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sreg   <= '0;
            idx    <= '0;
            rd_q   <= 1'b0;
        end else if (start && !active) begin
            active <= 1'b1;
            sreg   <= frame;
            idx    <= '0;
            rd_q   <= is_read;
        end else if (done) begin
            active <= 1'b0;
        end else if (active && fall) begin
            idx  <= idx + 1'b1;
            sreg <= {sreg[FRAME_W-2:0], 1'b1};
        end
    end

    // Read capture: shift in PHY data on rising MDC during the data field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (active && rise && rd_q && (idx >= IW'(RDAT_IDX))) begin
            rx_word <= {rx_word[WORD_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/mdio_cmd_engine.sv
// Module: top of the MDIO command engine. Holds the command and data words,
// decodes a command into a frame, and routes it to the internal or
// external bus. Assumes software waits for busy to clear between commands.
module mdio_cmd_engine
    import mdio_eng_pkg::*;
#(
    parameter int DIV_HALF  = 2,
    parameter int AW        = 5,
    parameter int CMD_ADDR  = 24,
    parameter int DATA_ADDR = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mdc_int,
    output logic              mdio_int_o,
    output logic              mdio_int_oe,
    input  logic              mdio_int_i,
    output logic              mdc_ext,
    output logic              mdio_ext_o,
    output logic              mdio_ext_oe,
    input  logic              mdio_ext_i
);
    localparam int NBUS = 2;

    cmd_t               cmd_q;
    cmd_t               cmd_in;
    logic [WORD_W-1:0]  data_q;
    logic               hit_cmd, hit_data, launch, in_read;
    logic [FRAME_W-1:0] frame;
    logic               mdc, rise, fall, active, sdo, sdo_oe, done, sdi;
    logic [WORD_W-1:0]  rx_word;
    logic [NBUS-1:0]    bus_on, mdc_b, mdo_b, oe_b;

    assign cmd_in   = cmd_t'(reg_wdata);
    assign hit_cmd  = reg_wr && (reg_addr == AW'(CMD_ADDR));
    assign hit_data = reg_wr && (reg_addr == AW'(DATA_ADDR));
    assign launch   = hit_cmd && !cmd_q.busy && cmd_in.busy &&
                      (cmd_in.func == FN_INT || cmd_in.func == FN_EXT);
    assign in_read  = cmd_in.op[1];

    // Frame assembly from the incoming command and the current data word.
    always_comb begin
        frame = {{PRE_W{1'b1}},
                 cmd_in.c22 ? 2'b01 : 2'b00,
                 cmd_in.op, cmd_in.phy, cmd_in.regad,
                 in_read ? 2'b11 : 2'b10,
                 in_read ? {WORD_W{1'b1}} : data_q};
    end

    // Command word: store while idle, set busy on launch, clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (hit_cmd && !cmd_q.busy) begin
            cmd_q      <= cmd_in;
            cmd_q.busy <= launch;
        end else if (done) begin
            cmd_q.busy <= 1'b0;
        end
    end

    // Data word: load from software while idle, take the read result on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done && cmd_q.op[1]) begin
            data_q <= rx_word;
        end else if (hit_data && !cmd_q.busy) begin
            data_q <= reg_wdata;
        end
    end

    // Register read mux.
    always_comb begin
        if (reg_addr == AW'(CMD_ADDR))       reg_rdata = cmd_q;
        else if (reg_addr == AW'(DATA_ADDR)) reg_rdata = data_q;
        else                                 reg_rdata = '0;
    end

    mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(active),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_framer u_frm (
        .clk(clk), .rst_n(rst_n), .start(launch), .frame(frame),
        .is_read(in_read), .rise(rise), .fall(fall), .sdi(sdi),
        .active(active), .sdo(sdo), .sdo_oe(sdo_oe), .done(done),
        .rx_word(rx_word)
    );

    assign sdi = cmd_q.func[0] ? mdio_ext_i : mdio_int_i;

    // Bus steering: bus 0 is internal, bus 1 external; idle bus stays quiet.
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        assign bus_on[b] = active && (cmd_q.func[0] == (b == 1));
        assign mdc_b[b]  = mdc && bus_on[b];
        assign mdo_b[b]  = bus_on[b] ? sdo : 1'b1;
        assign oe_b[b]   = bus_on[b] && sdo_oe;
    end

    assign mdc_int     = mdc_b[0];
    assign mdio_int_o  = mdo_b[0];
    assign mdio_int_oe = oe_b[0];
    assign mdc_ext     = mdc_b[1];
    assign mdio_ext_o  = mdo_b[1];
    assign mdio_ext_oe = oe_b[1];
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
// Module: property checker for mdio_cmd_engine, attached by bind.
// Assumes the bound signals are the top's ports and register words.
module mdio_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cmd_q,
    input logic [15:0] data_q,
    input logic        mdc_int,
    input logic        mdc_ext,
    input logic        mdio_int_oe,
    input logic        mdio_ext_oe
);
    logic busy;
    assign busy = cmd_q[15];

    // R5
    one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mdc_int && mdc_ext) && !(mdio_int_oe && mdio_ext_oe));

    // R10
    idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc_int && !mdc_ext));

    // R7
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_int_oe || mdio_ext_oe) |-> busy);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q[14:0]));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(data_q) || !busy));

    // R3
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!mdc_int && !mdc_ext));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_q(cmd_q), .data_q(data_q),
    .mdc_int(mdc_int), .mdc_ext(mdc_ext),
    .mdio_int_oe(mdio_int_oe), .mdio_ext_oe(mdio_ext_oe)
);

// File: tb/mdio_cmd_engine_tb.sv
module mdio_cmd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;
    localparam logic [4:0] A_CMD  = 5'h18;
    localparam logic [4:0] A_DATA = 5'h19;

    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [4:0]  reg_addr = A_CMD;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic        mdc_int, mdio_int_o, mdio_int_oe, mdio_int_i = 1;
    logic        mdc_ext, mdio_ext_o, mdio_ext_oe, mdio_ext_i = 1;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    // responder state per bus: captured bits, rise count, rises with oe low
    logic [63:0] cap_i, cap_e;
    int nr_i = 0, nr_e = 0, lo_i = 0, lo_e = 0;
    logic [15:0] resp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc_int(mdc_int), .mdio_int_o(mdio_int_o), .mdio_int_oe(mdio_int_oe),
        .mdio_int_i(mdio_int_i), .mdc_ext(mdc_ext), .mdio_ext_o(mdio_ext_o),
        .mdio_ext_oe(mdio_ext_oe), .mdio_ext_i(mdio_ext_i)
    );

    always @(posedge mdc_int) begin
        cap_i = {cap_i[62:0], mdio_int_o};
        if (!mdio_int_oe) lo_i++;
        nr_i++;
    end
    always @(negedge mdc_int)
        mdio_int_i = (nr_i >= 48 && nr_i < 64) ? resp[63 - nr_i] : 1'b1;
    always @(posedge mdc_ext) begin
        cap_e = {cap_e[62:0], mdio_ext_o};
        if (!mdio_ext_oe) lo_e++;
        nr_e++;
    end
    always @(negedge mdc_ext)
        mdio_ext_i = (nr_e >= 48 && nr_e < 64) ? resp[63 - nr_e] : 1'b1;

    function automatic logic [63:0] exp_frame(input logic [15:0] c, input logic [15:0] d);
        return {32'hFFFF_FFFF, c[12] ? 2'b01 : 2'b00, c[11:10], c[9:5], c[4:0], 2'b10, d};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_addr = A_CMD;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = A_CMD;
    endtask

    task automatic clear_model();
        nr_i = 0; nr_e = 0; lo_i = 0; lo_e = 0; cap_i = 0; cap_e = 0;
    endtask

    // Issue one command and check the frame, timing and register results.
    // inject: during busy, try overwriting the command and the data words.
    task automatic do_cmd(input logic [15:0] c, input logic [15:0] d,
                          input logic [15:0] r, input bit inject);
        int n = 0;
        logic [15:0] v;
        logic [63:0] f, cap;
        int nr_sel, nr_oth, lo_sel;
        bit rd = c[11];
        wr_reg(A_DATA, d);
        resp = r;
        clear_model();
        @(negedge clk);
        reg_wr = 1; reg_addr = A_CMD; reg_wdata = c;
        @(posedge clk);
        forever begin
            @(negedge clk);
            reg_wr = 0; reg_addr = A_CMD;
            if (inject && n == 10) begin reg_wr = 1; reg_wdata = 16'hB3C5; end
            if (inject && n == 11) begin reg_wr = 1; reg_addr = A_DATA; reg_wdata = 16'h5A5A; end
            #1;
            if (!(inject && n == 11) && !reg_rdata[15]) break;
            n++;
            if (n > 2000) break;
        end
        reg_wr = 0; reg_addr = A_CMD;
        chk(n == 128*DIV_HALF, "R10", "busy cycles", 64'(n), 64'(128*DIV_HALF));
        f      = exp_frame(c, d);
        cap    = c[13] ? cap_e : cap_i;
        nr_sel = c[13] ? nr_e : nr_i;
        nr_oth = c[13] ? nr_i : nr_e;
        lo_sel = c[13] ? lo_e : lo_i;
        chk(nr_sel == 64 && nr_oth == 0, "R5", "mdc edges sel/other",
            {32'(nr_sel), 32'(nr_oth)}, {32'd64, 32'd0});
        chk(cap[63:18] == f[63:18], "R6", "frame header", 64'(cap[63:18]), 64'(f[63:18]));
        rd_reg(A_CMD, v);
        chk(v == (c & 16'h7FFF), inject ? "R9" : "R3", "command readback", 64'(v), 64'(c & 16'h7FFF));
        rd_reg(A_DATA, v);
        if (rd) begin
            chk(lo_sel == 18, "R8", "released rises", 64'(lo_sel), 64'd18);
            chk(v == r, "R8", "read result", 64'(v), 64'(r));
        end else begin
            chk(cap[17:0] == f[17:0] && lo_sel == 0, inject ? "R9" : "R7",
                "ta+data", 64'(cap[17:0]), 64'(f[17:0]));
            chk(v == d, inject ? "R9" : "R7", "data kept", 64'(v), 64'(d));
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        rd_reg(A_CMD, v);  chk(v == 0, "R1", "cmd after reset", 64'(v), 0);
        rd_reg(A_DATA, v); chk(v == 0, "R1", "data after reset", 64'(v), 0);
        chk({mdc_int, mdc_ext, mdio_int_oe, mdio_ext_oe} == 0, "R1", "bus idle",
            64'({mdc_int, mdc_ext, mdio_int_oe, mdio_ext_oe}), 0);
        // R2 map
        wr_reg(A_DATA, 16'hC0DE);
        rd_reg(A_DATA, v); chk(v == 16'hC0DE, "R2", "data reg", 64'(v), 64'h C0DE);
        rd_reg(5'h05, v);  chk(v == 0, "R2", "unmapped read", 64'(v), 0);
        wr_reg(A_CMD, 16'h1234);
        rd_reg(A_CMD, v);  chk(v == 16'h1234, "R2", "cmd reg idle store", 64'(v), 64'h1234);
        // R4 setup and reserved functions start nothing
        for (int k = 0; k < 2; k++) begin
            c = k ? 16'hE5A7 : 16'hC9C3;
            clear_model();
            wr_reg(A_CMD, c);
            repeat (300) @(posedge clk);
            rd_reg(A_CMD, v);
            chk(v == (c & 16'h7FFF), "R4", "no busy", 64'(v), 64'(c & 16'h7FFF));
            chk(nr_i == 0 && nr_e == 0, "R4", "no mdc", 64'(nr_i + nr_e), 0);
        end
        // directed: clause 22 write internal, clause 22 read external
        do_cmd(16'h9000 | 16'h0400 | (5'd1 << 5) | 5'd0, 16'hFFFF, 16'h0, 0);
        do_cmd(16'hB800 | (5'd31 << 5) | 5'd31, 16'h0000, 16'h8001, 0);
        // R11 clause 45 address write then read
        do_cmd(16'h8000 | (5'd3 << 5) | 5'd1, 16'h1234, 16'h0, 0);
        do_cmd(16'h8C00 | (5'd3 << 5) | 5'd1, 16'h0000, 16'hBEEF, 0);
        rd_reg(A_DATA, v); chk(v == 16'hBEEF, "R11", "c45 read value", 64'(v), 64'hBEEF);
        // R9 writes during busy are ignored
        do_cmd(16'hB400 | (5'd7 << 5) | 5'd9, 16'h6A6A, 16'h0, 1);
        // random commands
        for (int i = 0; i < 24; i++) begin
            logic [15:0] rc;
            logic        c22 = 1'($urandom);
            logic [1:0]  op  = c22 ? ((($urandom % 2) == 0) ? 2'b01 : 2'b10) : 2'($urandom);
            rc = {1'b1, 1'b0, 1'($urandom), c22, op, 5'($urandom), 5'($urandom)};
            do_cmd(rc, 16'($urandom), 16'($urandom), 0);
        end
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule